// File: doc/BRIEF.md
# Matrix Coprocessor Instruction Decoder with Enable Gate

This block sits between a host core's issue stage and a matrix coprocessor. Each cycle, the host may present one 32-bit instruction word together with a 64-bit value that it has already read from the general register named in that word. The block decides whether the word belongs to the coprocessor extension. For a word that belongs, it separates a 5-bit operation code from a 5-bit register-or-immediate field. It then forwards legal operations to the coprocessor and reports words that the host must trap on or handle itself.

The block owns a single enable flag for the context it serves. One reserved control opcode switches this flag. For that opcode, the low field is an immediate: 0 switches the flag on and 1 switches it off. Every other operation is only forwarded while the flag is set. Otherwise it comes back as an illegal instruction. All results are registered and appear one cycle after the input strobe.

Top module: `mxcp_decode_gate`

## Requirements
- R1: After reset, all outputs are low and zero, and the enable flag is clear. The first extension operation after reset therefore raises `illegal`.
- R2: A valid word whose bits 31:10 differ from the pattern given by (word & 0xFFFFFC00) == 0x00201000 raises only `notOurs`. It never changes the enable flag.
- R3: In a matching word, the opcode is bits 9:5 and the operand field is bits 4:0. Opcode values 23 to 31 raise only `notOurs` and leave the enable flag untouched.
- R4: Opcode 17 with field 0 sets the enable flag in any state, including when the flag is already set. It produces no dispatch, no `illegal` and no `notOurs`.
- R5: Opcode 17 with field 1, issued while enabled, clears the enable flag and produces no output pulse.
- R6: Opcode 17 with any field from 2 to 31, issued while enabled, is a no-op: no output pulse, and the flag keeps its value.
- R7: While the flag is clear, every extension word raises `illegal` and is not dispatched. This includes opcode 17 with a nonzero field. The only exception is opcode 17 with field 0.
- R8: While the flag is set, opcodes 0 to 16 and 18 to 22 pulse `dispValid`, with `dispOp` equal to the opcode and `dispOperand` equal to `srcData`.
- R9: For a dispatched operation whose operand field is 31, `dispOperand` is zero, whatever value `srcData` holds.
- R10: Each output pulse lasts one cycle and appears exactly one cycle after its `instValid` cycle. At most one of `dispValid`, `illegal` and `notOurs` is high in any cycle. `dispOp` and `dispOperand` are zero whenever `dispValid` is low.
- R11: A change of the enable flag applies to the very next word, including one issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word present this cycle |
| instWord | input | 32 | Instruction word from the host |
| srcData | input | 64 | Value of the register named by bits 4:0 |
| dispValid | output | 1 | One-cycle dispatch pulse to the coprocessor |
| dispOp | output | 5 | Opcode of the dispatched operation |
| dispOperand | output | 64 | Operand value for the dispatched operation |
| illegal | output | 1 | Word belongs to the extension but must trap |
| notOurs | output | 1 | Word is not an extension instruction |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 64-bit operand, 5-bit opcode and operand fields, 23 defined opcodes, control opcode 17 and zero index 31. With a 5-bit opcode field, all 32 codes can be issued, so the undefined range 23 to 31 is exercised next to the defined one. The operand field reaches both the control immediates 0 and 1 and the zero index 31. Scripted sequences toggle the enable flag in back-to-back cycles. A long pseudo-random phase then mixes foreign words, undefined opcodes and control words, so the flag changes state many times while the reference model tracks it.

// File: rtl/mxcp_pkg.sv
package mxcp_pkg;

  // Strobes from decode/control to the output datapath, valid in the input cycle
  typedef struct packed {
    logic dispatch;  // forward the operation
    logic trap;      // extension word that must raise illegal
    logic foreign;   // word outside the extension
    logic zeroSrc;   // operand field selects the hard zero
  } ctlStrobes_t;

endpackage

// File: rtl/mxcp_ctrl.sv
module mxcp_ctrl
  import mxcp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPC_W = 5,
  parameter int IDX_W = 5,
  parameter int NUM_OPS = 23,
  parameter int CTL_OP = 17,
  parameter int ON_IMM = 0,
  parameter int OFF_IMM = 1,
  parameter logic [WORD_W-1:0] MATCH_MASK = 32'hFFFF_FC00,
  parameter logic [WORD_W-1:0] MATCH_VAL = 32'h0020_1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  output ctlStrobes_t       strobes,
  output logic [OPC_W-1:0]  opField
);

  localparam int OPC_LSB = IDX_W;
  localparam logic [IDX_W-1:0] ZERO_IDX = {IDX_W{1'b1}};
  localparam logic [OPC_W-1:0] CTL_CODE = OPC_W'(CTL_OP);
  localparam logic [IDX_W-1:0] ON_CODE = IDX_W'(ON_IMM);
  localparam logic [IDX_W-1:0] OFF_CODE = IDX_W'(OFF_IMM);

  logic             enabled;
  logic [IDX_W-1:0] idxField;
  logic             isBase;
  logic             known;
  logic             isCtl;
  logic             wantOn;
  logic             wantOff;

  always_comb begin
    opField  = instWord[OPC_LSB +: OPC_W];
    idxField = instWord[IDX_W-1:0];
    isBase   = (instWord & MATCH_MASK) == MATCH_VAL;
    known    = isBase && (int'(opField) < NUM_OPS);
    isCtl    = known && (opField == CTL_CODE);
    wantOn   = isCtl && (idxField == ON_CODE);
    wantOff  = isCtl && (idxField == OFF_CODE);
  end

  always_comb begin
    strobes.foreign  = instValid && !known;
    strobes.trap     = instValid && known && !enabled && !wantOn;
    strobes.dispatch = instValid && known && !isCtl && enabled;
    strobes.zeroSrc  = (idxField == ZERO_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled <= 1'b0;
    end else if (instValid && wantOn) begin
      enabled <= 1'b1;
    end else if (instValid && wantOff && enabled) begin
      enabled <= 1'b0;
    end
  end

  // R4: an enable word sets the flag on the next cycle
  a_r4_enable_sets: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && ((instWord & MATCH_MASK) == MATCH_VAL)
     && instWord[OPC_LSB +: OPC_W] == CTL_CODE && instWord[IDX_W-1:0] == ON_CODE)
    |=> enabled);

  // R7: nothing is forwarded while the flag is clear
  a_r7_no_dispatch_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> !strobes.dispatch);

  // R2 and R3: foreign words leave the flag alone
  a_r2_foreign_keeps_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobes.foreign |=> $stable(enabled));

  // R6: control opcode with any other immediate is a no-op
  a_r6_ctl_noop: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && isCtl && idxField != ON_CODE && idxField != OFF_CODE) |=> $stable(enabled));

endmodule

// File: rtl/mxcp_dpath.sv
module mxcp_dpath
  import mxcp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OPC_W = 5,
  parameter int NUM_OPS = 23,
  parameter int CTL_OP = 17,
  parameter bit HAS_ZERO_IDX = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctlStrobes_t       strobes,
  input  logic [OPC_W-1:0]  opField,
  input  logic [DATA_W-1:0] srcData,
  output logic              dispValid,
  output logic [OPC_W-1:0]  dispOp,
  output logic [DATA_W-1:0] dispOperand,
  output logic              illegal,
  output logic              notOurs
);

  localparam logic [OPC_W-1:0] CTL_CODE = OPC_W'(CTL_OP);

  logic [DATA_W-1:0] operandSel;

  generate
    if (HAS_ZERO_IDX) begin : g_zeroIdx
      always_comb operandSel = strobes.zeroSrc ? '0 : srcData;
    end else begin : g_plain
      always_comb operandSel = srcData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispValid   <= 1'b0;
      illegal     <= 1'b0;
      notOurs     <= 1'b0;
      dispOp      <= '0;
      dispOperand <= '0;
    end else begin
      dispValid   <= strobes.dispatch;
      illegal     <= strobes.trap;
      notOurs     <= strobes.foreign;
      dispOp      <= strobes.dispatch ? opField : '0;
      dispOperand <= strobes.dispatch ? operandSel : '0;
    end
  end

  // R10: a single outcome per word
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dispValid, illegal, notOurs}));

  // R10: payload is quiet without a dispatch
  a_r10_quiet_payload: assert property (@(posedge clk) disable iff (!rstN)
    !dispValid |-> (dispOp == '0 && dispOperand == '0));

  // R10: every pulse is caused by an input word one cycle earlier
  a_r10_cause: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid || illegal || notOurs) |-> $past(inValid));

  // R8: only defined, non-control opcodes reach the coprocessor
  a_r8_op_legal: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (int'(dispOp) < NUM_OPS && dispOp != CTL_CODE));

  // R9: the zero index yields a zero operand
  a_r9_zero_operand: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && $past(strobes.zeroSrc)) |-> dispOperand == '0);

endmodule

// File: rtl/mxcp_decode_gate.sv
module mxcp_decode_gate
  import mxcp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DATA_W = 64,
  parameter int OPC_W = 5,
  parameter int IDX_W = 5,
  parameter int NUM_OPS = 23,
  parameter int CTL_OP = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  logic [DATA_W-1:0] srcData,
  output logic              dispValid,
  output logic [OPC_W-1:0]  dispOp,
  output logic [DATA_W-1:0] dispOperand,
  output logic              illegal,
  output logic              notOurs
);

  ctlStrobes_t      strobes;
  logic [OPC_W-1:0] opField;

  mxcp_ctrl #(
    .WORD_W(WORD_W), .OPC_W(OPC_W), .IDX_W(IDX_W),
    .NUM_OPS(NUM_OPS), .CTL_OP(CTL_OP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .strobes(strobes), .opField(opField)
  );

  mxcp_dpath #(
    .DATA_W(DATA_W), .OPC_W(OPC_W), .NUM_OPS(NUM_OPS), .CTL_OP(CTL_OP)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .inValid(instValid), .strobes(strobes),
    .opField(opField), .srcData(srcData),
    .dispValid(dispValid), .dispOp(dispOp), .dispOperand(dispOperand),
    .illegal(illegal), .notOurs(notOurs)
  );

endmodule

// File: tb/sim_mxcp_decode_gate.sv
`timescale 1ns/1ps
module sim_mxcp_decode_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [63:0] srcData = '0;
  logic        dispValid;
  logic [4:0]  dispOp;
  logic [63:0] dispOperand;
  logic        illegal;
  logic        notOurs;

  mxcp_decode_gate u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .srcData(srcData), .dispValid(dispValid), .dispOp(dispOp),
    .dispOperand(dispOperand), .illegal(illegal), .notOurs(notOurs)
  );

  always #2 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  bit    mEn = 1'b0;
  bit    eDv = 1'b0, eIl = 1'b0, eNo = 1'b0;
  logic [4:0]  eOp = '0;
  logic [63:0] eOpd = '0;
  string eTag = "R1";
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic [31:0] mk(input int op, input int idx);
    return 32'h0020_1000 | (32'(op & 31) << 5) | 32'(idx & 31);
  endfunction

  function automatic logic [63:0] nextRng(input logic [63:0] s);
    logic [63:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  task automatic compare();
    total++;
    if ({dispValid, illegal, notOurs} !== {eDv, eIl, eNo} || dispOp !== eOp || dispOperand !== eOpd) begin
      bad++;
      $display("FAIL %s: actual v=%0b ill=%0b no=%0b op=%0d opd=%h expected v=%0b ill=%0b no=%0b op=%0d opd=%h",
               eTag, dispValid, illegal, notOurs, dispOp, dispOperand, eDv, eIl, eNo, eOp, eOpd);
    end
  endtask

  // Behavioural reference: expected outputs for the next cycle
  task automatic model(input bit v, input logic [31:0] w, input logic [63:0] d, input string note);
    int op = int'(w[9:5]);
    int idx = int'(w[4:0]);
    eDv = 0; eIl = 0; eNo = 0; eOp = '0; eOpd = '0;
    if (!v) eTag = "R10";
    else if ((w & 32'hFFFF_FC00) != 32'h0020_1000) begin eNo = 1; eTag = "R2"; end
    else if (op > 22) begin eNo = 1; eTag = "R3"; end
    else if (op == 17) begin
      if (idx == 0) begin mEn = 1; eTag = "R4"; end
      else if (!mEn) begin eIl = 1; eTag = "R7"; end
      else if (idx == 1) begin mEn = 0; eTag = "R5"; end
      else eTag = "R6";
    end
    else if (!mEn) begin eIl = 1; eTag = "R7"; end
    else begin
      eDv = 1; eOp = w[9:5];
      eOpd = (idx == 31) ? 64'h0 : d;
      eTag = (idx == 31) ? "R9" : "R8";
    end
    if (note != "") eTag = note;
  endtask

  task automatic step(input bit v, input logic [31:0] w, input logic [63:0] d, input string note = "");
    @(negedge clk);
    compare();
    instValid = v; instWord = w; srcData = d;
    model(v, w, d, note);
  endtask

  initial begin
    eTag = "R1";
    repeat (3) step(0, '0, '0, "R1");
    rstN = 1'b1;
    step(0, '0, '0, "R1");
    // R1/R7: first extension op after reset traps
    step(1, mk(5, 3), 64'h1111, "R1");
    // R7: everything but the enable traps while disabled
    for (int op = 0; op < 23; op++) if (op != 17) step(1, mk(op, op), 64'hAB);
    step(1, mk(17, 1), '0);
    step(1, mk(17, 9), '0);
    // R2: near misses of the match pattern
    step(1, mk(17, 0) ^ 32'h0000_0400, '0);
    step(1, mk(17, 0) ^ 32'h8000_0000, '0);
    step(1, 32'hD503_201F, '0);
    step(0, '0, '0);
    step(1, mk(3, 2), 64'h5, "R2");  // still disabled after foreign words
    // R3: undefined opcodes
    for (int op = 23; op < 32; op++) step(1, mk(op, 0), '0);
    // R4 then R11 back-to-back dispatch
    step(1, mk(17, 0), '0);
    step(1, mk(3, 4), 64'hDEAD_BEEF_0000_0001, "R11");
    step(1, mk(17, 0), '0);            // repeated enable harmless
    // R8 all defined opcodes with varied data
    for (int op = 0; op < 23; op++)
      step(1, mk(op, op % 31), {32'(op) * 32'h0101_0101, 32'hC0DE_0000 | 32'(op)});
    // R9 zero index
    step(1, mk(10, 31), 64'hFFFF_FFFF_FFFF_FFFF);
    step(1, mk(22, 31), 64'h1234);
    // R6 no-op immediates then dispatch still works
    step(1, mk(17, 2), '0);
    step(1, mk(17, 31), '0);
    step(1, mk(0, 30), 64'h77, "R6");
    // R3/R2 with control pattern corrupted while enabled
    step(1, mk(17, 1) | 32'h0001_0000, '0);
    step(1, mk(1, 1), 64'h88, "R2");
    // R5 disable then R11 immediate trap
    step(1, mk(17, 1), '0);
    step(1, mk(14, 7), 64'h99, "R11");
    step(0, '0, '0);
    // pseudo-random mix
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] w;
      rng = nextRng(rng);
      if (rng[2:0] == 3'd0) w = rng[63:32];
      else if (rng[5:3] == 3'd0) w = mk(17, int'(rng[7:6]));
      else w = mk(int'(rng[12:8]), int'(rng[17:13]));
      step(rng[19:18] != 2'b00, w, nextRng(rng));
    end
    step(0, '0, '0);
    step(0, '0, '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R10: watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule